// File: doc/BRIEF.md
# Device Serial Number Streamer with Embedded CRC

This block keeps a 64-bit per-device serial number and hands it to a serial bus front end one byte at a time. The number is split into an upper half and a lower half, and each half is read in a separate access. Check bytes are inserted into the stream at fixed places. In the upper-half access, a CRC byte follows every data byte. In the lower-half access, a CRC byte follows every pair of data bytes. Each CRC byte covers every data byte sent so far in the current access. The CRC is CRC-8 with polynomial 0x31 (x^8+x^5+x^4+1), an initial value of 0x00, and processes data MSB first.

The front end handles the bus protocol itself. To open an access it pulses `start`, with `half_sel` choosing the half. After every master acknowledge it pulses `next`, and on a master not-acknowledge it pulses `stop`. The current byte is always present on `byte_out`. By convention, the first byte of the lower half (serial bits 31:24) carries a device variant code: 0x32, 0x33, 0x35, 0x36 or 0x37, or 0x00/0xFF for engineering samples. The block passes this byte through unchanged. The serial number resets to a parameter value and can be replaced through a load port while no access is open.

Top module: `sid_stream`

## Requirements
- R1: After reset, `streaming` is 0, `final_byte` is 0, `byte_out` is 0xFF, and the stored serial equals the DEFAULT_SERIAL parameter.
- R2: An access opened with `half_sel`=0 returns, one byte per `next`, the sequence U0,C,U1,C,U2,C,U3,C. Here U0 is serial bits 63:56, U1 is 55:48, U2 is 47:40, U3 is 39:32, and each C is a CRC byte.
- R3: An access opened with `half_sel`=1 returns L0,L1,C,L2,L3,C. Here L0 is serial bits 31:24, L1 is 23:16, L2 is 15:8 and L3 is 7:0.
- R4: Each CRC byte equals the CRC-8 (polynomial 0x31, initial 0x00, MSB first) of all data bytes already returned in the same access. The CRC restarts at every `start`.
- R5: A `next` on the last byte of an access gives 0xFF on `byte_out`, and the output stays 0xFF for any further `next` while `streaming` remains 1.
- R6: `stop` (without `start`) closes the access in the next cycle, after which `byte_out` is 0xFF. While no access is open, `next` has no effect and `streaming` stays 0.
- R7: `start` has priority over `stop` and `next`. It restarts at the first byte of the selected half, even in the middle of an access.
- R8: `load_en` replaces the stored serial with `load_value` only when no access is open and `start` is low. While streaming, it is ignored.
- R9: Without `next`, `start` or `stop`, `byte_out` holds its value from cycle to cycle during an access.
- R10: `final_byte` is 1 exactly while the last byte of the access (position 7 for the upper half, position 5 for the lower half) is on `byte_out`.
- R11: `half_sel` is sampled only with `start`. Changing it during an access has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Replace the stored serial number (idle only) |
| load_value | input | 64 | New serial number |
| start | input | 1 | Open an access to the half chosen by half_sel |
| half_sel | input | 1 | 0 = upper half, 1 = lower half |
| next | input | 1 | Advance to the next byte (master acknowledged) |
| stop | input | 1 | Close the access (master did not acknowledge) |
| byte_out | output | 8 | Current byte of the stream, 0xFF when none |
| streaming | output | 1 | An access is open |
| final_byte | output | 1 | The current byte is the last one of the access |

## Verification
The properties assume that every control input is a synchronous level sampled at one edge. They also assume the front end's rule that `start` overrides `stop` and `next` in the same cycle, so each property is qualified on the absence of the stronger controls. The bench drives every control for exactly one cycle from the falling clock edge. It never relies on an undefined combination, and it keeps `half_sel` deliberately toggled against the open half during every walk.

// File: rtl/sid_pkg.sv
package sid_pkg;

    // Which half of the serial number an access returns
    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_e;

    // Data bytes between CRC bytes, per half
    localparam int UPPER_DATA_PER_CRC = 1;
    localparam int LOWER_DATA_PER_CRC = 2;

endpackage

// File: rtl/sid_crc_step.sv
// One CRC byte update: MSB-first, whole data byte folded into the register.
module sid_crc_step #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    POLY = 'h31
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] acc;

    always_comb begin
        acc = crc_in ^ data_in;
        for (int b = 0; b < W; b++) begin
            acc = acc[W-1] ? ((acc << 1) ^ POLY) : (acc << 1);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/sid_layout.sv
// Decodes a stream position into data/CRC slot for one half's layout.
module sid_layout #(
    parameter int IDX_W        = 4,
    parameter int DATA_PER_CRC = 1,
    parameter int HALF_BYTES   = 4
) (
    input  logic [IDX_W-1:0] idx,
    output logic             is_crc,
    output logic [IDX_W-1:0] data_k,
    output logic             in_range,
    output logic             is_final
);
    localparam int GROUP = DATA_PER_CRC + 1;
    localparam int LEN   = (HALF_BYTES / DATA_PER_CRC) * GROUP;

    logic [IDX_W-1:0] grp;
    logic [IDX_W-1:0] rem;

    always_comb begin
        grp      = idx / IDX_W'(GROUP);
        rem      = idx % IDX_W'(GROUP);
        is_crc   = (rem == IDX_W'(DATA_PER_CRC));
        data_k   = grp * IDX_W'(DATA_PER_CRC) + rem;
        in_range = (idx < IDX_W'(LEN));
        is_final = (idx == IDX_W'(LEN - 1));
    end
endmodule

// File: rtl/sid_bytesel.sv
// Picks data byte k of the chosen half; byte 0 is the most significant.
module sid_bytesel #(
    parameter int SERIAL_W = 64,
    parameter int BYTE_W   = 8,
    parameter int SEL_W    = 4
) (
    input  logic [SERIAL_W-1:0] serial,
    input  logic                lower,
    input  logic [SEL_W-1:0]    k,
    output logic [BYTE_W-1:0]   byte_val
);
    localparam int NB = SERIAL_W / BYTE_W;
    localparam int HB = NB / 2;

    logic [BYTE_W-1:0] bytes [NB];
    logic [SEL_W:0]    sel;

    for (genvar g = 0; g < NB; g++) begin : g_split
        assign bytes[g] = serial[SERIAL_W-1-g*BYTE_W -: BYTE_W];
    end

    always_comb begin
        sel      = (lower ? (SEL_W+1)'(HB) : '0) + {1'b0, k};
        byte_val = '0;
        for (int g = 0; g < NB; g++) begin
            if (sel == (SEL_W+1)'(g)) byte_val = bytes[g];
        end
    end
endmodule

// File: rtl/sid_stream.sv
module sid_stream
    import sid_pkg::*;
#(
    parameter int                     SERIAL_W       = 64,
    parameter int                     BYTE_W         = 8,
    parameter logic [BYTE_W-1:0]      CRC_POLY       = 'h31,
    parameter logic [BYTE_W-1:0]      CRC_INIT       = '0,
    parameter logic [BYTE_W-1:0]      FILL           = '1,
    parameter logic [SERIAL_W-1:0]    DEFAULT_SERIAL = 64'h5E71_0C94_3300_A7F2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [SERIAL_W-1:0] load_value,
    input  logic                start,
    input  logic                half_sel,
    input  logic                next,
    input  logic                stop,
    output logic [BYTE_W-1:0]   byte_out,
    output logic                streaming,
    output logic                final_byte
);
    localparam int NBYTES     = SERIAL_W / BYTE_W;
    localparam int HALF_BYTES = NBYTES / 2;
    localparam int LEN_MAX    = HALF_BYTES * (UPPER_DATA_PER_CRC + 1) / UPPER_DATA_PER_CRC;
    localparam int IDX_W      = $clog2(LEN_MAX + 1);

    typedef struct packed {
        logic [SERIAL_W-1:0] serial;
        logic                act;
        half_e               half;
        logic [IDX_W-1:0]    idx;
        logic [BYTE_W-1:0]   crc;
    } st_t;

    localparam st_t RST_ST = '{
        serial: DEFAULT_SERIAL,
        act:    1'b0,
        half:   HALF_UPPER,
        idx:    '0,
        crc:    CRC_INIT
    };

    st_t s_d, s_q;

    logic             lower;
    logic [1:0]       pos_crc, pos_ok, pos_fin;
    logic [IDX_W-1:0] pos_k [2];
    logic [BYTE_W-1:0] cur_data;
    logic [BYTE_W-1:0] crc_nx;

    assign lower = (s_q.half == HALF_LOWER);

    // One layout decoder per half; the parameter picks its CRC spacing
    for (genvar h = 0; h < 2; h++) begin : g_layout
        sid_layout #(
            .IDX_W       (IDX_W),
            .DATA_PER_CRC(h == 0 ? UPPER_DATA_PER_CRC : LOWER_DATA_PER_CRC),
            .HALF_BYTES  (HALF_BYTES)
        ) u_layout (
            .idx     (s_q.idx),
            .is_crc  (pos_crc[h]),
            .data_k  (pos_k[h]),
            .in_range(pos_ok[h]),
            .is_final(pos_fin[h])
        );
    end

    sid_bytesel #(
        .SERIAL_W(SERIAL_W),
        .BYTE_W  (BYTE_W),
        .SEL_W   (IDX_W)
    ) u_bytesel (
        .serial  (s_q.serial),
        .lower   (lower),
        .k       (pos_k[lower]),
        .byte_val(cur_data)
    );

    sid_crc_step #(
        .W   (BYTE_W),
        .POLY(CRC_POLY)
    ) u_crc (
        .crc_in (s_q.crc),
        .data_in(cur_data),
        .crc_out(crc_nx)
    );

    // Next state
    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.act  = 1'b1;
            s_d.half = half_e'(half_sel);
            s_d.idx  = '0;
            s_d.crc  = CRC_INIT;
        end else if (stop) begin
            s_d.act  = 1'b0;
            s_d.idx  = '0;
            s_d.crc  = CRC_INIT;
        end else if (s_q.act && next && pos_ok[lower]) begin
            s_d.idx = s_q.idx + 1'b1;
            if (!pos_crc[lower]) s_d.crc = crc_nx;
        end
        if (!s_q.act && !start && load_en) begin
            s_d.serial = load_value;
        end
    end

    // Outputs
    always_comb begin
        streaming  = s_q.act;
        final_byte = s_q.act && pos_fin[lower];
        if (!s_q.act || !pos_ok[lower]) begin
            byte_out = FILL;
        end else if (pos_crc[lower]) begin
            byte_out = s_q.crc;
        end else begin
            byte_out = cur_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_ST;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sid_stream_chk.sv
module sid_stream_chk #(
    parameter int                BYTE_W = 8,
    parameter logic [BYTE_W-1:0] FILL   = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              stop,
    input logic              next,
    input logic [BYTE_W-1:0] byte_out,
    input logic              streaming,
    input logic              final_byte
);
    // R6
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !streaming |-> (byte_out == FILL && !final_byte));

    // R7
    start_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> streaming);

    // R6
    stop_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !streaming);

    // R6
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!streaming && !start) |=> !streaming);

    // R9
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (streaming && !next && !start && !stop) |=> $stable(byte_out));

    // R5
    past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (final_byte && next && !start && !stop) |=> (streaming && byte_out == FILL));

    // R10
    final_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (final_byte && next && !start && !stop) |=> !final_byte);
endmodule

bind sid_stream sid_stream_chk #(
    .BYTE_W(BYTE_W),
    .FILL  (FILL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .next      (next),
    .byte_out  (byte_out),
    .streaming (streaming),
    .final_byte(final_byte)
);

// File: tb/sid_stream_bench.sv
module sid_stream_bench;
    localparam logic [63:0] DEF = 64'hC3A5_1F08_3700_9B6E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_value = '0;
    logic        start = 1'b0;
    logic        half_sel = 1'b0;
    logic        next = 1'b0;
    logic        stop = 1'b0;
    logic [7:0]  byte_out;
    logic        streaming;
    logic        final_byte;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sid_stream #(.DEFAULT_SERIAL(DEF)) u_sid_stream (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_value(load_value),
        .start(start), .half_sel(half_sel), .next(next), .stop(stop),
        .byte_out(byte_out), .streaming(streaming), .final_byte(final_byte)
    );

    // {half, serial}; lower half leading byte carries a variant code
    localparam logic [64:0] TV [4] = '{
        {1'b0, 64'h0123_4567_89AB_CDEF},
        {1'b1, 64'h1A2B_3C4D_32F0_E1D2},
        {1'b1, 64'hFFFF_0000_FF00_00FF},
        {1'b0, 64'h0000_0000_3500_0000}
    };

    function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0} ^ (fb ? 8'h31 : 8'h00);
        end
        return r;
    endfunction

    function automatic int seq_len(input logic h);
        return h ? 6 : 8;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [63:0] s, input logic h, input int pos);
        logic [7:0] c = 8'h00;
        int p = 0;
        for (int j = 0; j < 4; j++) begin
            logic [7:0] b = s[63 - 8*(j + 4*h) -: 8];
            if (p == pos) return b;
            p++;
            c = crc_ref(c, b);
            if (!h || (j % 2 == 1)) begin
                if (p == pos) return c;
                p++;
            end
        end
        return 8'hFF;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive for one cycle from a falling edge, return at the next falling edge
    task automatic cyc(input logic s, input logic h, input logic n, input logic p,
                       input logic l, input logic [63:0] lv);
        start = s; half_sel = h; next = n; stop = p; load_en = l; load_value = lv;
        @(negedge clk);
        start = 0; next = 0; stop = 0; load_en = 0;
    endtask

    // Walks a whole access from the current byte; half_sel is held opposite (R11)
    task automatic walk(input logic [63:0] s, input logic h, input int from);
        for (int p = from; p < seq_len(h); p++) begin
            chk(64'(byte_out), 64'(exp_byte(s, h, p)),
                h ? "R3 R4 R11 lower byte" : "R2 R4 R11 upper byte");
            chk(64'(final_byte), 64'(p == seq_len(h) - 1), "R10 final flag");
            cyc(0, ~h, 1, 0, 0, '0);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk(64'(streaming), 0, "R1 streaming");
        chk(64'(byte_out), 64'hFF, "R1 byte_out");
        chk(64'(final_byte), 0, "R1 final");
        rst_n = 1'b1;
        @(negedge clk);

        // R1 default serial, both halves
        cyc(1, 0, 0, 0, 0, '0);
        walk(DEF, 1'b0, 0);
        cyc(1, 1, 0, 0, 0, '0);
        walk(DEF, 1'b1, 0);
        cyc(0, 0, 0, 1, 0, '0);

        // Vector table
        for (int t = 0; t < 4; t++) begin
            logic [63:0] sv = TV[t][63:0];
            logic        hv = TV[t][64];
            cyc(0, 0, 0, 0, 1, sv);               // R8 load while idle
            cyc(1, hv, 0, 0, 0, '0);
            chk(64'(streaming), 1, "R7 open");
            walk(sv, hv, 0);
            chk(64'(byte_out), 64'hFF, "R5 past end");
            chk(64'(streaming), 1, "R5 still open");
            cyc(0, 0, 1, 0, 0, '0);
            chk(64'(byte_out), 64'hFF, "R5 past end again");
            cyc(0, 0, 0, 1, 0, '0);
            chk(64'(streaming), 0, "R6 stop closes");
            chk(64'(byte_out), 64'hFF, "R6 idle fill");
        end

        // R9 hold without next
        cyc(0, 0, 0, 0, 1, TV[0][63:0]);
        cyc(1, 0, 0, 0, 0, '0);
        cyc(0, 0, 1, 0, 0, '0);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 1, 0, 0, 0, '0);
            chk(64'(byte_out), 64'(exp_byte(TV[0][63:0], 1'b0, 1)), "R9 hold");
        end

        // R7 restart mid-access into the other half, CRC restarts; R8 load ignored
        cyc(0, 0, 1, 0, 1, 64'hDEAD_BEEF_DEAD_BEEF);
        cyc(0, 0, 1, 0, 0, '0);
        cyc(1, 1, 1, 1, 0, '0);
        walk(TV[0][63:0], 1'b1, 0);
        cyc(1, 0, 0, 0, 0, '0);
        walk(TV[0][63:0], 1'b0, 0);                // R8 serial unchanged
        cyc(0, 0, 0, 1, 0, '0);

        // R6 next while idle ignored
        for (int i = 0; i < 3; i++) begin
            cyc(0, 0, 1, 0, 0, '0);
            chk(64'(streaming), 0, "R6 idle next");
            chk(64'(byte_out), 64'hFF, "R6 idle next byte");
        end
        cyc(1, 0, 0, 0, 0, '0);
        chk(64'(byte_out), 64'(TV[0][63:56]), "R6 idle next left position");

        // R8 load together with start is not taken
        cyc(0, 0, 0, 1, 0, '0);
        cyc(1, 0, 0, 0, 1, 64'h1111_1111_1111_1111);
        walk(TV[0][63:0], 1'b0, 0);
        cyc(0, 0, 0, 1, 0, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule